// File: doc/BRIEF.md
# Indexed Interrupt Redirection Controller

This block routes up to 64 interrupt input lines to a single processor-side interrupt unit. Each line owns a 64-bit redirection entry that holds the vector to raise, the destination ID, the pin polarity, the trigger mode and a mask bit. Software never addresses an entry directly. It writes a slot number into an index register and then reads or writes that slot through a data window register. A separate write-only register accepts an end-of-interrupt vector.

When a line requests service, the controller raises a vector message on a valid/acknowledge output and holds it until the processor side acknowledges it. A level-triggered line that has been accepted stays remote-pending and is not sent again until software writes its vector to the end-of-interrupt register. That write releases every level-triggered entry carrying the vector. An edge-triggered line sends once per active transition and never becomes remote-pending. When several lines request at once, the lowest-numbered line goes first.

Top module: `irq_route_ctl`

## Requirements
- R1: Host register port, single cycle: bus address 0 is the index register (read back in bits 7:0), bus address 1 is the window onto the slot selected by the index, and bus address 2 is the write-only end-of-interrupt register (vector in bits 7:0). Window reads of unused slots, and reads of addresses 2 and 3, return 0.
- R2: The entry of line n occupies window slot TABLE_BASE+2n (low word) and TABLE_BASE+2n+1 (high word). TABLE_BASE defaults to 16.
- R3: Low word: vector in 7:0, delivery mode in 10:8, destination mode in 11, delivery status in 12, polarity in 13, remote pending in 14, trigger mode in 15 (1 = level, 0 = edge) and mask in 16 (1 = disabled). Bits 31:17 read 0. High word: destination ID in 31:24, all other bits read 0.
- R4: Window slot 1 is read-only: bits 23:16 give NUM_LINES, bits 7:0 give VERSION_ID (default 0x11), and all other bits are 0.
- R5: After reset, every low word reads 0x0001_0000 and every high word reads 0.
- R6: Writes to low-word bits 12 and 14 are ignored. Those bits only reflect hardware state.
- R7: A masked line is never sent. Clearing the mask bit with a read-modify-write of the low word enables the line.
- R8: A message carries the entry's vector and destination ID. msg_valid stays high with a stable vector and destination until the cycle msg_ack is high. The line's delivery status bit reads 1 from launch until that acknowledge.
- R9: An acknowledged level-triggered line sets remote pending and is not sent again. An end-of-interrupt write clears remote pending on every level entry whose vector matches, and leaves the others set. If the input is still active afterwards, the line is sent again.
- R10: An edge-triggered line sends exactly one message for each rising transition of its polarity-adjusted input. It never sets remote pending, and an end-of-interrupt write has no effect on it.
- R11: Polarity bit 1 makes the input active low. Polarity bit 0 makes it active high.
- R12: When several unmasked lines request in the same cycle, the lowest-numbered line is sent first.
- R13: A request that becomes visible after a clock edge raises msg_valid at the following edge. After an acknowledge, msg_valid is low for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 index, 1 window, 2 end of interrupt |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| irq_in | input | NUM_LINES | Interrupt input lines |
| msg_valid | output | 1 | Vector message pending |
| msg_vector | output | 8 | Vector of the pending message |
| msg_dest | output | 8 | Destination ID of the pending message |
| msg_ack | input | 1 | Processor-side acceptance of the message |

## Verification
A corrupted remote-pending or edge-latch flop shows at the ports within two cycles. It appears either as a missing or repeated message on msg_valid, or as a wrong bit 14 on the next window read of the low word. A wrong entry field shows in the vector or destination of the next message, or in the low-word readback, which is checked across every line with arithmetic patterns. Priority and handshake faults show at the first launch after simultaneous requests, through vector order and through the line's delivery-status bit.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

   // host bus register selects
   localparam logic [1:0] BUS_INDEX  = 2'd0;
   localparam logic [1:0] BUS_WINDOW = 2'd1;
   localparam logic [1:0] BUS_EOI    = 2'd2;

   // window slot holding the version word
   localparam logic [7:0] SLOT_VERSION = 8'd1;

   // writable low-word configuration of one redirection entry
   typedef struct packed {
      logic       mask;
      logic       trig;    // 1 = level, 0 = edge
      logic       pol;     // 1 = active low
      logic       dstm;
      logic [2:0] dmode;
      logic [7:0] vec;
   } rte_cfg_t;

   function automatic logic [31:0] pack_low(input rte_cfg_t c, input logic dstat, input logic rpend);
      return {15'd0, c.mask, c.trig, rpend, c.pol, dstat, c.dstm, c.dmode, c.vec};
   endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int N  = 8,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   assign any_o = |req_i;

   generate
      if (N == 1) begin : g_single
         assign idx_o = '0;
      end else begin : g_scan
         always_comb begin
            idx_o = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req_i[i]) idx_o = IW'(i);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
   import irq_route_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        irq_i,
   input  logic        wr_lo_i,
   input  logic        wr_hi_i,
   input  logic [31:0] wdata_i,
   input  logic        eoi_i,
   input  logic [7:0]  eoi_vec_i,
   input  logic        inflight_i,
   input  logic        accept_i,
   output logic        req_o,
   output logic [7:0]  vec_o,
   output logic [7:0]  dest_o,
   output logic [31:0] lo_word_o,
   output logic [31:0] hi_word_o
);
   rte_cfg_t   cfg_q;
   logic [7:0] dest_q;
   logic       rpend_q;
   logic       edge_q;
   logic       act_q;
   logic       active;
   logic       unused_wbits;

   assign unused_wbits = ^{wdata_i[23:17], wdata_i[14], wdata_i[12]};
   assign active = irq_i ^ cfg_q.pol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         cfg_q.mask <= 1'b1;
         dest_q     <= '0;
         rpend_q    <= 1'b0;
         edge_q     <= 1'b0;
         act_q      <= 1'b0;
      end else begin
         act_q <= active;
         if (wr_lo_i) begin
            cfg_q.vec   <= wdata_i[7:0];
            cfg_q.dmode <= wdata_i[10:8];
            cfg_q.dstm  <= wdata_i[11];
            cfg_q.pol   <= wdata_i[13];
            cfg_q.trig  <= wdata_i[15];
            cfg_q.mask  <= wdata_i[16];
         end
         if (wr_hi_i) dest_q <= wdata_i[31:24];
         // level acceptance latches remote pending; matching EOI releases it
         if (accept_i && cfg_q.trig)
            rpend_q <= 1'b1;
         else if (eoi_i && cfg_q.trig && (eoi_vec_i == cfg_q.vec))
            rpend_q <= 1'b0;
         // edge capture, dropped while masked or in level mode
         if (cfg_q.mask || cfg_q.trig)
            edge_q <= 1'b0;
         else if (active && !act_q)
            edge_q <= 1'b1;
         else if (accept_i)
            edge_q <= 1'b0;
      end
   end

   assign req_o = !cfg_q.mask && !inflight_i &&
                  (cfg_q.trig ? (active && !rpend_q) : edge_q);
   assign vec_o     = cfg_q.vec;
   assign dest_o    = dest_q;
   assign lo_word_o = pack_low(cfg_q, inflight_i, rpend_q);
   assign hi_word_o = {dest_q, 24'd0};

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inflight_i) |-> $past(cfg_q.mask) == 1'b0); // R7
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q.trig && rpend_q) |=> !$rose(inflight_i)); // R9
   AST_EOI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && cfg_q.trig && eoi_vec_i == cfg_q.vec && !accept_i) |=> !rpend_q); // R9
   AST_EDGE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rpend_q) |-> ($past(cfg_q.trig) && $past(accept_i))); // R10
endmodule

// File: rtl/irq_route_ctl.sv
module irq_route_ctl
   import irq_route_pkg::*;
#(
   parameter int         NUM_LINES  = 8,
   parameter int         TABLE_BASE = 16,
   parameter logic [7:0] VERSION_ID = 8'h11
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] irq_in,
   output logic                 msg_valid,
   output logic [7:0]           msg_vector,
   output logic [7:0]           msg_dest,
   input  logic                 msg_ack
);
   localparam int LW        = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int TABLE_END = TABLE_BASE + 2 * NUM_LINES;

   generate
      if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
         $error("NUM_LINES must be 1..64");
      end
      if ((TABLE_BASE % 2) != 0 || TABLE_BASE < 2 || TABLE_END > 256) begin : g_bad_base
         $error("TABLE_BASE must be even, at least 2, and the table must fit 8-bit slots");
      end
   endgenerate

   logic [7:0]           idx_q;
   logic                 busy_q;
   logic [LW-1:0]        cur_q;
   logic [7:0]           vec_q, dest_q;
   logic                 idx_wr, win_wr, eoi_wr, in_table;
   logic [7:0]           slot_off;
   logic [NUM_LINES-1:0] req, dstat, accept, wr_lo, wr_hi;
   logic [7:0]           line_vec  [NUM_LINES];
   logic [7:0]           line_dest [NUM_LINES];
   logic [31:0]          lo_w      [NUM_LINES];
   logic [31:0]          hi_w      [NUM_LINES];
   logic                 pick_any;
   logic [LW-1:0]        pick_idx;
   logic [7:0]           pick_vec, pick_dest;

   assign idx_wr   = bus_sel && bus_wr && (bus_addr == BUS_INDEX);
   assign win_wr   = bus_sel && bus_wr && (bus_addr == BUS_WINDOW);
   assign eoi_wr   = bus_sel && bus_wr && (bus_addr == BUS_EOI);
   assign slot_off = idx_q - 8'(TABLE_BASE);
   assign in_table = ({1'b0, idx_q} >= 9'(TABLE_BASE)) && ({1'b0, idx_q} < 9'(TABLE_END));

   generate
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
         assign wr_lo[i]  = win_wr && in_table && (slot_off[7:1] == 7'(i)) && !slot_off[0];
         assign wr_hi[i]  = win_wr && in_table && (slot_off[7:1] == 7'(i)) &&  slot_off[0];
         assign dstat[i]  = busy_q && (cur_q == LW'(i));
         assign accept[i] = dstat[i] && msg_ack;

         irq_line_cell u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq_i      (irq_in[i]),
            .wr_lo_i    (wr_lo[i]),
            .wr_hi_i    (wr_hi[i]),
            .wdata_i    (bus_wdata),
            .eoi_i      (eoi_wr),
            .eoi_vec_i  (bus_wdata[7:0]),
            .inflight_i (dstat[i]),
            .accept_i   (accept[i]),
            .req_o      (req[i]),
            .vec_o      (line_vec[i]),
            .dest_o     (line_dest[i]),
            .lo_word_o  (lo_w[i]),
            .hi_word_o  (hi_w[i])
         );
      end
   endgenerate

   irq_pick #(.N(NUM_LINES), .IW(LW)) u_pick (
      .req_i (req),
      .any_o (pick_any),
      .idx_o (pick_idx)
   );

   always_comb begin
      pick_vec  = '0;
      pick_dest = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (pick_idx == LW'(i)) begin
            pick_vec  = line_vec[i];
            pick_dest = line_dest[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         busy_q <= 1'b0;
         cur_q  <= '0;
         vec_q  <= '0;
         dest_q <= '0;
      end else begin
         if (idx_wr) idx_q <= bus_wdata[7:0];
         if (!busy_q) begin
            if (pick_any) begin
               busy_q <= 1'b1;
               cur_q  <= pick_idx;
               vec_q  <= pick_vec;
               dest_q <= pick_dest;
            end
         end else if (msg_ack) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         BUS_INDEX: bus_rdata = {24'd0, idx_q};
         BUS_WINDOW: begin
            if (idx_q == SLOT_VERSION)
               bus_rdata = {8'd0, 8'(NUM_LINES), 8'd0, VERSION_ID};
            else if (in_table) begin
               for (int i = 0; i < NUM_LINES; i++) begin
                  if (slot_off[7:1] == 7'(i))
                     bus_rdata = slot_off[0] ? hi_w[i] : lo_w[i];
               end
            end
         end
         default: bus_rdata = '0;
      endcase
   end

   assign msg_valid  = busy_q;
   assign msg_vector = vec_q;
   assign msg_dest   = dest_q;

   AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dstat)); // R8
   AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ack) |=> (msg_valid && $stable(msg_vector) && $stable(msg_dest))); // R8
   AST_ACK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ack) |=> !msg_valid); // R13
endmodule

// File: tb/irq_route_ctl_tb.sv
`timescale 1ns/100ps
module irq_route_ctl_tb_top;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NL-1:0] irq_in = '0;
   logic          msg_valid;
   logic [7:0]    msg_vector, msg_dest;
   logic          msg_ack = 1'b0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   irq_route_ctl #(.NUM_LINES(NL), .TABLE_BASE(16), .VERSION_ID(8'h11)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_in(irq_in), .msg_valid(msg_valid), .msg_vector(msg_vector),
      .msg_dest(msg_dest), .msg_ack(msg_ack)
   );

   function automatic logic [7:0] lo_slot(input int n); return 8'(16 + 2 * n); endfunction
   function automatic logic [7:0] hi_slot(input int n); return 8'(17 + 2 * n); endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #0.5 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic win_write(input logic [7:0] s, input logic [31:0] d);
      bus_write(2'd0, {24'd0, s});
      bus_write(2'd1, d);
   endtask

   task automatic win_read(input logic [7:0] s, output logic [31:0] d);
      bus_write(2'd0, {24'd0, s});
      bus_read(2'd1, d);
   endtask

   task automatic ack_msg();
      @(negedge clk); msg_ack = 1'b1;
      @(negedge clk); msg_ack = 1'b0;
   endtask

   task automatic expect_msg(input string tag, input logic [7:0] vec);
      bit got = 1'b0;
      for (int k = 0; k < 12 && !got; k++) begin
         if (msg_valid) got = 1'b1; else @(negedge clk);
      end
      chk(tag, {31'd0, got}, 32'd1);
      chk(tag, {24'd0, msg_vector}, {24'd0, vec});
   endtask

   task automatic expect_quiet(input string tag, input int cycles);
      bit seen = 1'b0;
      for (int k = 0; k < cycles; k++) begin
         @(negedge clk);
         if (msg_valid) seen = 1'b1;
      end
      chk(tag, {31'd0, seen}, 32'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] r, pat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 reset state, R4 version word, R1 index readback and unused slots
      for (int n = 0; n < NL; n++) begin
         win_read(lo_slot(n), r); chk("R5 reset low word", r, 32'h0001_0000);
         win_read(hi_slot(n), r); chk("R5 reset high word", r, 32'h0);
      end
      chk("R13 idle after reset", {31'd0, msg_valid}, 32'd0);
      win_read(8'd1, r); chk("R4 version", r, 32'h0004_0011);
      bus_read(2'd0, r); chk("R1 index readback", r, 32'd1);
      win_read(8'd40, r); chk("R1 unused slot", r, 32'h0);
      bus_read(2'd2, r); chk("R1 eoi reads zero", r, 32'h0);

      // R2/R3/R6 field layout sweep, entries kept masked
      for (int n = 0; n < NL; n++) begin
         pat = (32'h1357_9BDF * (n + 1)) ^ 32'hA5C3_0F5A | 32'h0001_5000;
         win_write(lo_slot(n), pat);
         win_write(hi_slot(n), pat);
      end
      for (int n = 0; n < NL; n++) begin
         pat = (32'h1357_9BDF * (n + 1)) ^ 32'hA5C3_0F5A | 32'h0001_5000;
         win_read(lo_slot(n), r); chk("R3 R6 low word fields", r, pat & 32'h0001_AFFF);
         win_read(hi_slot(n), r); chk("R2 R3 high word fields", r, pat & 32'hFF00_0000);
      end
      chk("R7 masked sweep silent", {31'd0, msg_valid}, 32'd0);
      for (int n = 0; n < NL; n++) begin
         win_write(lo_slot(n), 32'h0001_0000);
         win_write(hi_slot(n), 32'h0);
      end

      // level line 1
      irq_in[1] = 1'b1;
      win_write(lo_slot(1), 32'h0001_D041);
      win_write(hi_slot(1), 32'h0500_0000);
      win_read(lo_slot(1), r); chk("R6 read-only bits ignored", r, 32'h0001_8041);
      expect_quiet("R7 masked level line silent", 6);
      win_read(lo_slot(1), r);
      bus_write(2'd1, r & ~32'h0001_0000);
      chk("R13 no launch before next edge", {31'd0, msg_valid}, 32'd0);
      @(negedge clk);
      chk("R7 R13 unmasked line launches", {31'd0, msg_valid}, 32'd1);
      chk("R8 vector", {24'd0, msg_vector}, 32'h41);
      chk("R8 destination", {24'd0, msg_dest}, 32'h05);
      win_read(lo_slot(1), r); chk("R8 delivery status set", r, 32'h0000_9041);
      repeat (3) @(negedge clk);
      chk("R8 held until ack", {31'd0, msg_valid}, 32'd1);
      ack_msg();
      chk("R13 low after ack", {31'd0, msg_valid}, 32'd0);
      win_read(lo_slot(1), r); chk("R9 remote pending set", r, 32'h0000_C041);
      expect_quiet("R9 no resend while pending", 6);
      bus_write(2'd2, 32'h42);
      win_read(lo_slot(1), r); chk("R9 other vector eoi keeps pending", r, 32'h0000_C041);
      bus_write(2'd2, 32'h41);
      expect_msg("R9 resend after eoi", 8'h41);
      irq_in[1] = 1'b0;
      ack_msg();
      bus_write(2'd2, 32'h41);
      expect_quiet("R9 inactive input not resent", 5);
      win_read(lo_slot(1), r); chk("R9 pending cleared", r, 32'h0000_8041);

      // edge line 2
      win_write(lo_slot(2), 32'h0000_0052);
      win_write(hi_slot(2), 32'h0700_0000);
      expect_quiet("R10 no edge no message", 4);
      @(negedge clk); irq_in[2] = 1'b1;
      expect_msg("R10 edge launches", 8'h52);
      chk("R8 edge destination", {24'd0, msg_dest}, 32'h07);
      ack_msg();
      expect_quiet("R10 single message per edge", 6);
      win_read(lo_slot(2), r); chk("R10 no remote pending", r, 32'h0000_0052);
      bus_write(2'd2, 32'h52);
      expect_quiet("R10 eoi no effect", 4);
      @(negedge clk); irq_in[2] = 1'b0;
      @(negedge clk); irq_in[2] = 1'b1;
      expect_msg("R10 second edge", 8'h52);
      ack_msg();

      // polarity line 3
      irq_in[3] = 1'b1;
      win_write(lo_slot(3), 32'h0000_A063);
      expect_quiet("R11 high input inactive", 5);
      @(negedge clk); irq_in[3] = 1'b0;
      expect_msg("R11 low input active", 8'h63);
      irq_in[3] = 1'b1;
      ack_msg();
      bus_write(2'd2, 32'h63);
      expect_quiet("R11 released after inactive", 4);

      // priority with edges on lines 0 and 2
      irq_in[2] = 1'b0;
      win_write(lo_slot(0), 32'h0000_0030);
      expect_quiet("R12 setup quiet", 3);
      @(negedge clk); irq_in[0] = 1'b1; irq_in[2] = 1'b1;
      expect_msg("R12 lowest line first", 8'h30);
      ack_msg();
      expect_msg("R12 higher line next", 8'h52);
      ack_msg();

      // shared vector on two level lines
      irq_in[0] = 1'b0; irq_in[2] = 1'b0;
      win_write(lo_slot(0), 32'h0000_8041);
      @(negedge clk); irq_in[0] = 1'b1; irq_in[1] = 1'b1;
      expect_msg("R12 shared vector first", 8'h41);
      win_read(lo_slot(0), r); chk("R12 line 0 in flight", r, 32'h0000_9041);
      ack_msg();
      expect_msg("R12 shared vector second", 8'h41);
      win_read(lo_slot(1), r); chk("R12 line 1 in flight", r, 32'h0000_9041);
      irq_in[0] = 1'b0; irq_in[1] = 1'b0;
      ack_msg();
      win_read(lo_slot(0), r); chk("R9 line 0 pending", r, 32'h0000_C041);
      win_read(lo_slot(1), r); chk("R9 line 1 pending", r, 32'h0000_C041);
      bus_write(2'd2, 32'h41);
      win_read(lo_slot(0), r); chk("R9 eoi clears line 0", r, 32'h0000_8041);
      win_read(lo_slot(1), r); chk("R9 eoi clears line 1", r, 32'h0000_8041);
      expect_quiet("R9 final quiet", 4);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule